// File: doc/BRIEF.md
# Load/store pipe interlock controller

This block tracks occupancy and hold conditions of a four-stage load/store pipe. The stages, in order, are dispatch (register access), address generation, cache access and write-back. Each cycle issue may offer one instruction, which carries a class code, an issue-slot index and a floating-point flag. The block decides whether it is captured into dispatch and which stages advance. It reports per-stage valid bits, a stall back to issue and a strobe that marks when a load's data becomes usable. No addresses, cache contents or data values pass through it.

Beyond the plain in-order flow, the block applies several interlocks. It lets only one reservation-type atomic (load-reserve or store-conditional) be in flight past dispatch at a time. A store-conditional leaves dispatch only in a cycle where the complex-integer dispatch stage also grants it. Both atomics are accepted only from issue slot 0. A memory barrier keeps the stages behind it empty until it commits from write-back. A floating-point load spends one extra cycle in write-back.

Top module: `ldst_pipe_ctl`

## Requirements
- R1: An instruction captured at a clock edge is in dispatch for the following cycle. With no hold anywhere it moves one stage per cycle through address generation, cache access and write-back. `stage_vld_o` bit 0 is dispatch, bit 1 address generation, bit 2 cache access and bit 3 write-back.
- R2: Class codes are 0 load, 1 store, 2 load-reserve, 3 store-conditional and 4 barrier; codes 5 to 7 behave as a load. Every class other than store and barrier stays in dispatch while `opnd_rdy_i` is low.
- R3: A store leaves dispatch without regard to `opnd_rdy_i`. It then stays in address generation while `st_data_rdy_i` is low.
- R4: A load-reserve or store-conditional in dispatch does not advance while another of either kind sits in address generation or cache access, or sits in write-back and is not leaving in that cycle.
- R5: A store-conditional leaves dispatch only in a cycle where `cplx_grant_i` is high.
- R6: A load-reserve or store-conditional offered with `disp_slot_i` not all zeros is not captured: `stall_o` is high for as long as it is offered, and it is taken once it is offered on slot 0.
- R7: While a barrier sits in address generation or cache access, or sits in write-back without leaving, nothing leaves dispatch. Address generation and cache access stay empty behind it.
- R8: A barrier leaves write-back only when address generation and cache access are both empty. A floating-point load (class 0 with `disp_fp_i` high) stays two cycles in write-back and holds cache access behind it. Every other instruction stays one cycle.
- R9: `ld_rdy_o` is high for one cycle right after a load or load-reserve leaves write-back. For an integer load that is 3 cycles after it enters address generation; for a floating-point load it is 4 cycles.
- R10: A stage advances only when the next stage is empty or advances in the same cycle. `stall_o` is high exactly when an instruction is offered and not captured.
- R11: While `rst_ni` is low, all stage valid bits and `ld_rdy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Instruction offered to dispatch |
| disp_cls_i | input | 3 | Class code of the offered instruction |
| disp_slot_i | input | SLOT_W | Issue slot the instruction comes from |
| disp_fp_i | input | 1 | Offered load targets floating-point registers |
| opnd_rdy_i | input | 1 | Operands ready for the instruction held in dispatch |
| st_data_rdy_i | input | 1 | Store data ready for the store held in address generation |
| cplx_grant_i | input | 1 | Complex-integer dispatch stage granted this cycle |
| stage_vld_o | output | 4 | Per-stage occupancy, bit 0 dispatch to bit 3 write-back |
| stall_o | output | 1 | Offered instruction not captured this cycle |
| ld_rdy_o | output | 1 | Load data usable this cycle |

## Verification
The bench targets the following corner cases.

- **Back-to-back atomics.** A load-reserve followed directly by a store-conditional must release in the cycle the first one leaves write-back. A design that cleared the reservation flag one cycle late would show the store-conditional entering address generation a cycle after the model does.
- **Atomic on slot 1.** A design that dropped such an offer, or captured it, would show `stall_o` low while the model expects it high.
- **Barrier stuck behind a waiting store.** Younger loads must not slip into address generation. A design that let them through would raise bit 1 of `stage_vld_o` early.
- **Floating-point loads mixed with integer loads.** A design that made the extra write-back cycle, the strobe or the backward stall propagation wrong would misplace `ld_rdy_o` or the valid bits.
- **Long mixed random run.** This run covers the interactions between all of the above.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
package ldst_pkg;
  localparam int CLS_W = 3;
  localparam int NSTG  = 4;
  localparam int S_RD  = 0;
  localparam int S_AG  = 1;
  localparam int S_CR  = 2;
  localparam int S_WB  = 3;

  localparam logic [CLS_W-1:0] CLS_LD    = 3'd0;
  localparam logic [CLS_W-1:0] CLS_ST    = 3'd1;
  localparam logic [CLS_W-1:0] CLS_LRES  = 3'd2;
  localparam logic [CLS_W-1:0] CLS_SCOND = 3'd3;
  localparam logic [CLS_W-1:0] CLS_BAR   = 3'd4;

  typedef struct packed {
    logic             vld;
    logic [CLS_W-1:0] cls;
    logic             fp;
  } stg_t;

  function automatic logic cls_atom(input logic [CLS_W-1:0] c);
    return (c == CLS_LRES) || (c == CLS_SCOND);
  endfunction

  // anything that writes a GPR/FPR from memory
  function automatic logic cls_ldlike(input logic [CLS_W-1:0] c);
    return !((c == CLS_ST) || (c == CLS_SCOND) || (c == CLS_BAR));
  endfunction

  function automatic logic cls_needs_opnd(input logic [CLS_W-1:0] c);
    return !((c == CLS_ST) || (c == CLS_BAR));
  endfunction
endpackage

// File: rtl/ldst_stage_reg.sv
`timescale 1ns/1ps
module ldst_stage_reg
  import ldst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic drop_i,
  input  stg_t d_i,
  output stg_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (take_i) q_o <= d_i;
    else if (drop_i) q_o <= '0;
  end
endmodule

// File: rtl/ldst_wb_ctl.sv
`timescale 1ns/1ps
module ldst_wb_ctl
  import ldst_pkg::*;
#(
  parameter int FP_WB_CYC  = 2,
  parameter int INT_WB_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  stg_t wb_i,
  input  logic front_busy_i,
  output logic leave_o,
  output logic ld_rdy_o
);
  localparam int DW_W = (FP_WB_CYC > 1) ? $clog2(FP_WB_CYC + 1) : 1;
  localparam logic [DW_W-1:0] FP_LAST  = DW_W'(FP_WB_CYC - 1);
  localparam logic [DW_W-1:0] INT_LAST = DW_W'(INT_WB_CYC - 1);

  logic [DW_W-1:0] dwell_q;
  logic            is_bar, is_fpld;
  logic [DW_W-1:0] last;

  assign is_bar  = (wb_i.cls == CLS_BAR);
  assign is_fpld = (wb_i.cls == CLS_LD) && wb_i.fp;
  assign last    = is_fpld ? FP_LAST : INT_LAST;

  // barrier commits only once the stages behind it are drained
  assign leave_o = wb_i.vld && (is_bar ? !front_busy_i : (dwell_q >= last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dwell_q  <= '0;
      ld_rdy_o <= 1'b0;
    end else begin
      ld_rdy_o <= leave_o && cls_ldlike(wb_i.cls);
      if (take_i)                              dwell_q <= '0;
      else if (wb_i.vld && !leave_o && !is_bar) dwell_q <= dwell_q + 1'b1;
    end
  end
endmodule

// File: rtl/ldst_hazard.sv
`timescale 1ns/1ps
module ldst_hazard
  import ldst_pkg::*;
#(
  parameter int NS = NSTG
) (
  input  logic [NS-1:0] vld_i,
  input  logic [NS-1:0] atom_i,
  input  logic [NS-1:1] bar_i,
  input  logic          sc_rd_i,
  input  logic          opnd_rd_i,
  input  logic          st_ag_i,
  input  logic          wb_leave_i,
  input  logic          opnd_rdy_i,
  input  logic          st_data_rdy_i,
  input  logic          cplx_grant_i,
  input  logic          disp_valid_i,
  input  logic          disp_atom_i,
  input  logic          disp_slot0_i,
  output logic [NS-1:0] adv_o,
  output logic          accept_o,
  output logic          stall_o
);
  logic [NS-1:1] live;
  logic          resv_busy, bar_pend;

  // an entry leaving write-back this cycle no longer counts as in flight
  always_comb begin
    live         = vld_i[NS-1:1];
    live[NS-1]   = vld_i[NS-1] && !wb_leave_i;
    resv_busy    = |(live & atom_i[NS-1:1]);
    bar_pend     = |(live & bar_i);
  end

  always_comb begin
    adv_o        = '0;
    adv_o[S_WB]  = wb_leave_i;
    adv_o[S_CR]  = vld_i[S_CR] && (!vld_i[S_WB] || adv_o[S_WB]);
    adv_o[S_AG]  = vld_i[S_AG] && (!vld_i[S_CR] || adv_o[S_CR]) &&
                   (!st_ag_i || st_data_rdy_i);
    adv_o[S_RD]  = vld_i[S_RD] && (!vld_i[S_AG] || adv_o[S_AG]) &&
                   (!opnd_rd_i || opnd_rdy_i) &&
                   !(atom_i[S_RD] && resv_busy) &&
                   !(sc_rd_i && !cplx_grant_i) &&
                   !bar_pend;
    accept_o     = disp_valid_i && (!disp_atom_i || disp_slot0_i) &&
                   (!vld_i[S_RD] || adv_o[S_RD]);
    stall_o      = disp_valid_i && !accept_o;
  end
endmodule

// File: rtl/ldst_pipe_ctl.sv
`timescale 1ns/1ps
module ldst_pipe_ctl
  import ldst_pkg::*;
#(
  parameter int SLOT_W     = 1,
  parameter int FP_WB_CYC  = 2,
  parameter int INT_WB_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [CLS_W-1:0]  disp_cls_i,
  input  logic [SLOT_W-1:0] disp_slot_i,
  input  logic              disp_fp_i,
  input  logic              opnd_rdy_i,
  input  logic              st_data_rdy_i,
  input  logic              cplx_grant_i,
  output logic [NSTG-1:0]   stage_vld_o,
  output logic              stall_o,
  output logic              ld_rdy_o
);
  stg_t            stg_q [NSTG];
  stg_t            stg_d [NSTG];
  logic [NSTG-1:0] take, drop, adv;
  logic [NSTG-1:0] is_atom_v, is_bar_v;
  logic            accept, wb_leave, front_busy;
  logic            sc_rd, opnd_rd, st_ag;

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    if (i == S_RD) begin : g_head
      assign stg_d[i] = '{vld: 1'b1, cls: disp_cls_i, fp: disp_fp_i};
      assign take[i]  = accept;
    end else begin : g_body
      assign stg_d[i] = stg_q[i-1];
      assign take[i]  = adv[i-1];
    end
    assign drop[i] = adv[i];

    ldst_stage_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take[i]),
      .drop_i (drop[i]),
      .d_i    (stg_d[i]),
      .q_o    (stg_q[i])
    );

    assign stage_vld_o[i] = stg_q[i].vld;
    assign is_atom_v[i]   = cls_atom(stg_q[i].cls);
    assign is_bar_v[i]    = (stg_q[i].cls == CLS_BAR);
  end

  assign sc_rd      = (stg_q[S_RD].cls == CLS_SCOND);
  assign opnd_rd    = cls_needs_opnd(stg_q[S_RD].cls);
  assign st_ag      = (stg_q[S_AG].cls == CLS_ST);
  assign front_busy = stg_q[S_AG].vld || stg_q[S_CR].vld;

  ldst_wb_ctl #(
    .FP_WB_CYC  (FP_WB_CYC),
    .INT_WB_CYC (INT_WB_CYC)
  ) u_wb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take[S_WB]),
    .wb_i         (stg_q[S_WB]),
    .front_busy_i (front_busy),
    .leave_o      (wb_leave),
    .ld_rdy_o     (ld_rdy_o)
  );

  ldst_hazard #(.NS(NSTG)) u_haz (
    .vld_i         (stage_vld_o),
    .atom_i        (is_atom_v),
    .bar_i         (is_bar_v[NSTG-1:1]),
    .sc_rd_i       (sc_rd),
    .opnd_rd_i     (opnd_rd),
    .st_ag_i       (st_ag),
    .wb_leave_i    (wb_leave),
    .opnd_rdy_i    (opnd_rdy_i),
    .st_data_rdy_i (st_data_rdy_i),
    .cplx_grant_i  (cplx_grant_i),
    .disp_valid_i  (disp_valid_i),
    .disp_atom_i   (cls_atom(disp_cls_i)),
    .disp_slot0_i  (disp_slot_i == '0),
    .adv_o         (adv),
    .accept_o      (accept),
    .stall_o       (stall_o)
  );
endmodule

// File: rtl/ldst_pipe_ctl_chk.sv
`timescale 1ns/1ps
module ldst_pipe_ctl_chk
  import ldst_pkg::*;
#(
  parameter int SLOT_W = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              disp_valid_i,
  input logic [CLS_W-1:0]  disp_cls_i,
  input logic [SLOT_W-1:0] disp_slot_i,
  input logic              cplx_grant_i,
  input logic              st_data_rdy_i,
  input logic              stall_o,
  input logic [NSTG-1:0]   stage_vld_o,
  input logic [NSTG-1:1]   atom_v,
  input logic [NSTG-1:0]   bar_v,
  input logic              sc_rd,
  input logic              st_ag
);
  // R10
  stall_needs_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> disp_valid_i);

  // R6
  atom_slot_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && (disp_cls_i == CLS_LRES || disp_cls_i == CLS_SCOND) &&
     disp_slot_i != '0) |-> stall_o);

  // R4
  single_resv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stage_vld_o[NSTG-1:1] & atom_v) <= 1);

  // R7
  bar_shadow_cr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[S_CR] && bar_v[S_CR]) |-> !stage_vld_o[S_AG]);

  // R7
  bar_shadow_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[S_WB] && bar_v[S_WB]) |-> !(stage_vld_o[S_AG] || stage_vld_o[S_CR]));

  // R7
  bar_rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[S_RD] && bar_v[S_RD] && stage_vld_o[S_AG] && bar_v[S_AG])
    |=> (stage_vld_o[S_RD] && bar_v[S_RD]));

  // R5
  sc_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[S_RD] && sc_rd && !cplx_grant_i) |=> (stage_vld_o[S_RD] && sc_rd));

  // R3
  st_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[S_AG] && st_ag && !st_data_rdy_i) |=> (stage_vld_o[S_AG] && st_ag));
endmodule

bind ldst_pipe_ctl ldst_pipe_ctl_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .disp_valid_i  (disp_valid_i),
  .disp_cls_i    (disp_cls_i),
  .disp_slot_i   (disp_slot_i),
  .cplx_grant_i  (cplx_grant_i),
  .st_data_rdy_i (st_data_rdy_i),
  .stall_o       (stall_o),
  .stage_vld_o   (stage_vld_o),
  .atom_v        (is_atom_v[NSTG-1:1]),
  .bar_v         (is_bar_v),
  .sc_rd         (sc_rd),
  .st_ag         (st_ag)
);

// File: tb/ldst_pipe_ctl_tb.sv
`timescale 1ns/1ps
module ldst_pipe_ctl_tb;
  localparam int C_LD = 0, C_ST = 1, C_LR = 2, C_SC = 3, C_BAR = 4;
  localparam int FPW = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dv = 1'b0;
  logic [2:0] cls = '0;
  logic [0:0] slot = '0;
  logic       fp = 1'b0;
  logic       opnd = 1'b1;
  logic       st_rdy = 1'b1;
  logic       grant = 1'b1;
  logic [3:0] stage_vld;
  logic       stall, ld_rdy;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R11";
  bit    done = 1'b0;

  // reference state: per stage valid/class/fp, write-back dwell, strobe
  int mv[4], mc[4], mf[4];
  int mdw = 0;
  bit mldr = 1'b0;

  always #10 clk = ~clk;

  ldst_pipe_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .disp_valid_i(dv), .disp_cls_i(cls),
    .disp_slot_i(slot), .disp_fp_i(fp), .opnd_rdy_i(opnd),
    .st_data_rdy_i(st_rdy), .cplx_grant_i(grant),
    .stage_vld_o(stage_vld), .stall_o(stall), .ld_rdy_o(ld_rdy)
  );

  function automatic bit is_at(int c); return c == C_LR || c == C_SC; endfunction
  function automatic bit ld_like(int c); return !(c == C_ST || c == C_SC || c == C_BAR); endfunction
  function automatic bit wants_op(int c); return !(c == C_ST || c == C_BAR); endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cyc %0d %s act %0d exp %0d", cur_req, cyc, what, act, exp);
    end
  endtask

  task automatic step(output bit acc);
    int need, nv[4], nc[4], nf[4], ndw;
    bit wl, cra, aga, rda, resv, barp, nldr;
    int ev;
    #5;
    need = (mc[3] == C_LD && mf[3] != 0) ? FPW : 1;
    if (mv[3] != 0 && mc[3] == C_BAR) wl = !(mv[1] != 0 || mv[2] != 0);
    else wl = (mv[3] != 0) && (mdw + 1 >= need);
    cra = mv[2] != 0 && (mv[3] == 0 || wl);
    aga = mv[1] != 0 && (mv[2] == 0 || cra) && (mc[1] != C_ST || st_rdy);
    resv = 0; barp = 0;
    for (int i = 1; i < 4; i++)
      if (mv[i] != 0 && !(i == 3 && wl)) begin
        if (is_at(mc[i])) resv = 1;
        if (mc[i] == C_BAR) barp = 1;
      end
    rda = mv[0] != 0 && (mv[1] == 0 || aga) && (!wants_op(mc[0]) || opnd) &&
          !(is_at(mc[0]) && resv) && !(mc[0] == C_SC && !grant) && !barp;
    acc = dv && (!is_at(int'(cls)) || slot == 0) && (mv[0] == 0 || rda);
    ev = 0;
    for (int i = 0; i < 4; i++) if (mv[i] != 0) ev |= (1 << i);
    chk("stage_vld", int'(stage_vld), ev);
    chk("stall", int'(stall), int'(dv && !acc));
    chk("ld_rdy", int'(ld_rdy), int'(mldr));
    nv = mv; nc = mc; nf = mf; ndw = mdw;
    nldr = wl && ld_like(mc[3]);
    if (wl) nv[3] = 0; else if (mv[3] != 0) ndw = mdw + 1;
    if (cra) begin nv[3] = 1; nc[3] = mc[2]; nf[3] = mf[2]; nv[2] = 0; ndw = 0; end
    if (aga) begin nv[2] = 1; nc[2] = mc[1]; nf[2] = mf[1]; nv[1] = 0; end
    if (rda) begin nv[1] = 1; nc[1] = mc[0]; nf[1] = mf[0]; nv[0] = 0; end
    if (acc) begin nv[0] = 1; nc[0] = int'(cls); nf[0] = int'(fp); end
    @(posedge clk);
    mv = nv; mc = nc; mf = nf; mdw = ndw; mldr = nldr;
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    bit a;
    dv = 1'b0;
    for (int i = 0; i < n; i++) step(a);
  endtask

  task automatic offer(int c, int s, bit f);
    bit a;
    dv = 1'b1; cls = 3'(c); slot = 1'(s); fp = f;
    for (int i = 0; i < 60; i++) begin
      step(a);
      if (a) break;
    end
    dv = 1'b0;
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mc[i] = 0; mf[i] = 0; end
    // R11: reset state
    repeat (3) @(negedge clk);
    #5;
    chk("rst stage_vld", int'(stage_vld), 0);
    chk("rst ld_rdy", int'(ld_rdy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R1";  offer(C_LD, 0, 0); idle(6);
    cur_req = "R2";  opnd = 0; offer(C_LD, 0, 0); idle(3); opnd = 1; idle(6);
    cur_req = "R3";  opnd = 0; st_rdy = 0; offer(C_ST, 0, 0); idle(4);
                     st_rdy = 1; opnd = 1; idle(5);
    cur_req = "R4";  offer(C_LR, 0, 0); offer(C_SC, 0, 0); offer(C_LR, 0, 0); idle(10);
    cur_req = "R5";  grant = 0; offer(C_SC, 0, 0); idle(3); grant = 1; idle(6);
    cur_req = "R6";  dv = 1; cls = 3'(C_LR); slot = 1; fp = 0;
                     repeat (3) step(a);
                     offer(C_LR, 0, 0); idle(6);
    cur_req = "R7";  offer(C_LD, 0, 0); offer(C_BAR, 0, 0); offer(C_LD, 0, 0);
                     offer(C_BAR, 0, 0); offer(C_LD, 0, 0); idle(10);
                     st_rdy = 0; offer(C_ST, 0, 0); offer(C_BAR, 0, 0); offer(C_LD, 0, 0);
                     idle(3); st_rdy = 1; idle(10);
    cur_req = "R8";  offer(C_LD, 0, 1); offer(C_LD, 0, 0); offer(C_LD, 0, 1);
                     offer(C_ST, 0, 0); idle(8);
    cur_req = "R9";  offer(C_LD, 0, 0); idle(2); offer(C_LD, 0, 1); idle(7);
    cur_req = "R10";
    for (int i = 0; i < 1500; i++) begin
      dv     = ($urandom_range(0, 3) != 0);
      cls    = 3'($urandom_range(0, 5));
      slot   = ($urandom_range(0, 5) == 0);
      fp     = $urandom_range(0, 1);
      opnd   = ($urandom_range(0, 3) != 0);
      st_rdy = ($urandom_range(0, 2) != 0);
      grant  = ($urandom_range(0, 2) != 0);
      step(a);
    end
    opnd = 1; st_rdy = 1; grant = 1;
    idle(20);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog cyc %0d act running exp finished", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule